// File: doc/BRIEF.md
# Single-Channel Burst DMA Controller

This block is a one-channel direct memory access engine that shares a processor/memory bus with a CPU. While it does not own the bus it behaves as a small slave register file. The CPU reaches that file through a select input, a two-bit register select and read/write strobes on a data bus. The CPU loads a start address, a word count and a direction, then sets a start bit.

Once started, the controller raises a bus request and waits for the grant. It then takes over the memory address and the memory read/write strobes. It moves the whole block, one word at a time, between memory and a single peripheral data port. The peripheral paces the transfer with a request/acknowledge pair. When the count runs out, the controller gives the bus back, raises a done flag and pulses an interrupt.

The state machine has six states:
- IDLE: waits for the start bit.
- REQ: bus request raised, waiting for the grant.
- WAITP: bus owned, waiting for the peripheral.
- ACC1: first cycle of a memory access.
- ACC2: second cycle of a memory access.
- FIN: completion.

Its transitions are:
- IDLE→REQ: start with a non-zero count.
- IDLE→FIN: start with a zero count.
- REQ→WAITP: grant seen high.
- WAITP→ACC1: peripheral request high and no acknowledge pending.
- ACC1→ACC2: always.
- ACC2→WAITP: more words remain.
- ACC2→FIN: the last word.
- FIN→IDLE: always.

Top module: `burst_dma_ctrl`

## Requirements
- R1: After reset, every register reads back zero, and the bus request, bus drive, memory strobes, peripheral acknowledge and interrupt are all low.
- R2: With `sel_i` high and `bgnt_i` low, the CPU can write and read back the registers. Select 00 is the address, 01 the word count, 10 the control register (bit 0 start, bit 1 direction, 1 = memory to peripheral) and 11 the status register (bit 0 busy, bit 1 done). `rdata_o` is zero whenever no register read is in progress.
- R3: Setting the start bit with a non-zero count raises `breq_o` and holds it. No memory strobe, and no bus drive, occurs before `bgnt_i` has been seen high.
- R4: With direction 1, words are read from consecutive memory addresses starting at the programmed address. Each word is handed to the peripheral on `per_wdata_o`, qualified by a one-cycle `per_ack_o`.
- R5: With direction 0, each word taken from `per_rdata_i` is written to consecutive memory addresses, and each word is acknowledged with `per_ack_o`.
- R6: Every word uses exactly two cycles of one memory strobe. A new access begins only after `per_req_i` was high in the previous cycle, so the transfer stalls while the peripheral request is low.
- R7: After each word the address register increases by one and the count register decreases by one. After a block of N words, the address reads start+N and the count reads 0.
- R8: In the cycle after the last access, `breq_o` and `bus_own_o` are low and `irq_o` pulses for exactly one cycle. After that pulse the status reads busy=0, done=1, and the start bit reads 0.
- R9: A start with a count of zero performs no memory access, never raises `breq_o`, and completes with done and one interrupt pulse.
- R10: Any CPU write to the control register clears the done flag.
- R11: CPU register writes are ignored while the controller is busy (start bit set).
- R12: `mem_rd_o` and `mem_wr_o` are never high together, and a strobe is only high while `breq_o` and `bus_own_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Controller select for CPU register access |
| rsel_i | input | 2 | Register select from the address bus |
| rd_i | input | 1 | CPU read strobe (honoured only while grant is low) |
| wr_i | input | 1 | CPU write strobe (honoured only while grant is low) |
| wdata_i | input | DW | CPU write data |
| rdata_o | output | DW | CPU read data |
| breq_o | output | 1 | Bus request |
| bgnt_i | input | 1 | Bus grant |
| bus_own_o | output | 1 | Controller drives the address bus and the memory strobes |
| mem_addr_o | output | AW | Memory address (zero when not driven) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Data written to memory |
| mem_rdata_i | input | DW | Data read from memory |
| per_req_i | input | 1 | Peripheral ready for a word |
| per_ack_o | output | 1 | One-cycle pulse: a word was taken from or given to the peripheral |
| per_rdata_i | input | DW | Word supplied by the peripheral |
| per_wdata_o | output | DW | Word delivered to the peripheral |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a CPU write that arrives after the start bit is set but before the grant comes back. In that window the CPU strobes are still honoured at the bus, yet the controller must discard the write. The bench holds the grant low for a chosen number of cycles after it sees the request, and it issues address, count and control writes inside that window. It then confirms that the final address and count follow the original programming. Mid-burst peripheral stalls are produced by dropping the peripheral request on a fixed cycle pattern, so that some accesses find it low at the point where they would begin.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAITP,
        ST_ACC1,
        ST_ACC2,
        ST_FIN
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    rsel,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          finish,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] count_q,
    output logic          start_q,
    output logic          dir_q,
    output logic          done_q,
    output logic [DW-1:0] rdata
);

    logic       write_ok;
    logic [1:0] ctl_w;

    assign write_ok = wr_en && !start_q;
    assign ctl_w    = 2'(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (finish) begin
            start_q <= 1'b0;
            done_q  <= 1'b1;
        end else if (step) begin
            addr_q  <= addr_q + AW'(1);
            count_q <= count_q - CW'(1);
        end else if (write_ok) begin
            unique case (rsel)
                SEL_ADDR: addr_q  <= AW'(wdata);
                SEL_CNT:  count_q <= CW'(wdata);
                SEL_CTRL: begin
                    start_q <= ctl_w[0];
                    dir_q   <= ctl_w[1];
                    done_q  <= 1'b0;
                end
                SEL_STAT: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (rsel)
                SEL_ADDR: rdata = DW'(addr_q);
                SEL_CNT:  rdata = DW'(count_q);
                SEL_CTRL: rdata = DW'({dir_q, start_q});
                SEL_STAT: rdata = DW'({done_q, start_q});
            endcase
        end
    end

endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir,
    input  logic last,
    input  logic zero,
    input  logic grant,
    input  logic per_req,
    input  logic ack_pending,
    output logic breq,
    output logic own,
    output logic mem_rd,
    output logic mem_wr,
    output logic step,
    output logic finish,
    output logic load_per,
    output logic irq
);

    dma_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = zero ? ST_FIN : ST_REQ;
            ST_REQ:   if (grant) state_d = ST_WAITP;
            ST_WAITP: if (per_req && !ack_pending) state_d = ST_ACC1;
            ST_ACC1:  state_d = ST_ACC2;
            ST_ACC2:  state_d = last ? ST_FIN : ST_WAITP;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        breq     = 1'b0;
        own      = 1'b0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        load_per = 1'b0;
        irq      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  breq = 1'b1;
            ST_WAITP: begin
                breq     = 1'b1;
                own      = 1'b1;
                load_per = !dir && per_req && !ack_pending;
            end
            ST_ACC1: begin
                breq   = 1'b1;
                own    = 1'b1;
                mem_rd = dir;
                mem_wr = !dir;
            end
            ST_ACC2: begin
                breq   = 1'b1;
                own    = 1'b1;
                mem_rd = dir;
                mem_wr = !dir;
                step   = 1'b1;
            end
            ST_FIN: begin
                finish = 1'b1;
                irq    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_data_latch.sv
module dma_data_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_per,
    input  logic [DW-1:0] per_data,
    input  logic          load_mem,
    input  logic [DW-1:0] mem_data,
    input  logic          ack_set,
    output logic [DW-1:0] word_q,
    output logic          ack_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            if (load_per)      word_q <= per_data;
            else if (load_mem) word_q <= mem_data;
            ack_q <= ack_set;
        end
    end

endmodule

// File: rtl/burst_dma_ctrl.sv
module burst_dma_ctrl #(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic [1:0]    rsel_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          breq_o,
    input  logic          bgnt_i,
    output logic          bus_own_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          per_req_i,
    output logic          per_ack_o,
    input  logic [DW-1:0] per_rdata_i,
    output logic [DW-1:0] per_wdata_o,
    output logic          irq_o
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic          cpu_ok;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] count_q;
    logic          start_q, dir_q, done_q;
    logic          step, finish, load_per, own;
    logic [DW-1:0] word_q;

    assign cpu_ok = sel_i && !bgnt_i;

    dma_regfile #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cpu_ok && wr_i),
        .rd_en   (cpu_ok && rd_i),
        .rsel    (rsel_i),
        .wdata   (wdata_i),
        .step    (step),
        .finish  (finish),
        .addr_q  (addr_q),
        .count_q (count_q),
        .start_q (start_q),
        .dir_q   (dir_q),
        .done_q  (done_q),
        .rdata   (rdata_o)
    );

    dma_burst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_q),
        .dir         (dir_q),
        .last        (count_q == CNT_ONE),
        .zero        (count_q == '0),
        .grant       (bgnt_i),
        .per_req     (per_req_i),
        .ack_pending (per_ack_o),
        .breq        (breq_o),
        .own         (own),
        .mem_rd      (mem_rd_o),
        .mem_wr      (mem_wr_o),
        .step        (step),
        .finish      (finish),
        .load_per    (load_per),
        .irq         (irq_o)
    );

    dma_data_latch #(.DW(DW)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_per (load_per),
        .per_data (per_rdata_i),
        .load_mem (step && dir_q),
        .mem_data (mem_rdata_i),
        .ack_set  (step),
        .word_q   (word_q),
        .ack_q    (per_ack_o)
    );

    assign bus_own_o   = own;
    assign mem_addr_o  = own ? addr_q : '0;
    assign mem_wdata_o = word_q;
    assign per_wdata_o = word_q;

endmodule

// File: rtl/dma_burst_chk.sv
module dma_burst_chk (
    input logic clk,
    input logic rst_n,
    input logic breq_o,
    input logic bgnt_i,
    input logic bus_own_o,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic per_req_i,
    input logic per_ack_o,
    input logic irq_o
);

    logic strobe;
    assign strobe = mem_rd_o || mem_wr_o;

    // R12
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R12
    strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (breq_o && bus_own_o));

    // R3
    own_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own_o) |-> $past(bgnt_i));

    // R3
    req_before_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(breq_o) |-> !bus_own_o);

    // R6
    access_needs_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(per_req_i));

    // R4
    ack_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack_o |-> $past(strobe));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R8
    irq_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!breq_o && !bus_own_o));

endmodule

bind burst_dma_ctrl dma_burst_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .breq_o    (breq_o),
    .bgnt_i    (bgnt_i),
    .bus_own_o (bus_own_o),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .per_req_i (per_req_i),
    .per_ack_o (per_ack_o),
    .irq_o     (irq_o)
);

// File: tb/tb_burst_dma_ctrl.sv
`timescale 1ns/1ps
module tb_burst_dma_ctrl;

    typedef struct packed {
        logic        dir;
        logic        stall;
        logic        busy_wr;
        logic [3:0]  gdly;
        logic [15:0] saddr;
        logic [15:0] cnt;
    } job_t;

    localparam int NJOBS = 4;
    localparam job_t JOBS [NJOBS] = '{
        '{dir:1'b1, stall:1'b0, busy_wr:1'b0, gdly:4'd3, saddr:16'h0010, cnt:16'd5},
        '{dir:1'b0, stall:1'b0, busy_wr:1'b1, gdly:4'd0, saddr:16'h0040, cnt:16'd4},
        '{dir:1'b1, stall:1'b1, busy_wr:1'b1, gdly:4'd6, saddr:16'h0080, cnt:16'd3},
        '{dir:1'b0, stall:1'b1, busy_wr:1'b0, gdly:4'd2, saddr:16'h00C0, cnt:16'd1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel_i = 0, rd_i = 0, wr_i = 0, bgnt_i = 0, per_req_i = 0;
    logic [1:0]  rsel_i = 0;
    logic [15:0] wdata_i = 0;
    logic [15:0] rdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i, per_rdata_i, per_wdata_o;
    logic        breq_o, bus_own_o, mem_rd_o, mem_wr_o, per_ack_o, irq_o;

    always #4 clk = ~clk;

    burst_dma_ctrl dut (.*);

    logic [15:0] mem  [256];
    logic [15:0] sink [16];
    logic        mon_clr = 0;
    logic        stall_en = 0;
    logic [15:0] cur_saddr = 0;
    int          strobe_cyc, early, conflict, breq_seen, irq_cnt, irq_bad, ack_idx;
    logic        prev_strobe, irq_after_strobe;
    int          cyc = 0;
    int          n_checks = 0, n_fail = 0;

    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    assign per_rdata_i = 16'hA000 + cur_saddr + 16'(ack_idx);

    function automatic logic [15:0] mem_init(input int a);
        return 16'(a * 3 + 16'h0101);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            strobe_cyc <= 0; early <= 0; conflict <= 0; breq_seen <= 0;
            irq_cnt <= 0; irq_bad <= 0; ack_idx <= 0;
            prev_strobe <= 0; irq_after_strobe <= 0;
        end else begin
            if (mem_rd_o || mem_wr_o) strobe_cyc <= strobe_cyc + 1;
            if ((mem_rd_o || mem_wr_o) && !bgnt_i) early <= early + 1;
            if (mem_rd_o && mem_wr_o) conflict <= conflict + 1;
            if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
            if (per_ack_o) begin
                sink[ack_idx[3:0]] <= per_wdata_o;
                ack_idx <= ack_idx + 1;
            end
            if (breq_o) breq_seen <= breq_seen + 1;
            if (irq_o) begin
                irq_cnt <= irq_cnt + 1;
                if (breq_o || bus_own_o) irq_bad <= irq_bad + 1;
                irq_after_strobe <= prev_strobe;
            end
            prev_strobe <= mem_rd_o || mem_wr_o;
        end
    end

    always @(negedge clk) per_req_i <= stall_en ? (cyc[1:0] != 2'b00) : 1'b1;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] rs, input logic [15:0] d);
        @(negedge clk);
        sel_i = 1; rsel_i = rs; wr_i = 1; wdata_i = d;
        @(negedge clk);
        sel_i = 0; wr_i = 0;
    endtask

    task automatic cpu_rd(input logic [1:0] rs, output logic [15:0] d);
        @(negedge clk);
        sel_i = 1; rsel_i = rs; rd_i = 1;
        #1 d = rdata_o;
        @(negedge clk);
        sel_i = 0; rd_i = 0;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1;
        @(negedge clk); mon_clr = 0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && irq_cnt == 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        bgnt_i = 0;
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
        mon_clr = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_clr = 0;

        // R1: reset state
        check(!breq_o && !bus_own_o && !mem_rd_o && !mem_wr_o && !irq_o && !per_ack_o,
              "R1 outputs", {breq_o, bus_own_o, mem_rd_o, mem_wr_o, irq_o}, 0);
        for (int r = 0; r < 4; r++) begin
            cpu_rd(2'(r), v);
            check(v == 0, "R1 register", v, 0);
        end

        // R2: readback
        cpu_wr(2'd0, 16'h1234); cpu_rd(2'd0, v); check(v == 16'h1234, "R2 addr", v, 16'h1234);
        cpu_wr(2'd1, 16'h0042); cpu_rd(2'd1, v); check(v == 16'h0042, "R2 count", v, 16'h0042);
        cpu_wr(2'd2, 16'h0002); cpu_rd(2'd2, v); check(v == 16'h0002, "R2 ctrl dir", v, 2);
        @(negedge clk); #1 check(rdata_o == 0, "R2 idle rdata", rdata_o, 0);

        // table-driven bursts: R3 R4 R5 R6 R7 R8 R11
        for (int j = 0; j < NJOBS; j++) begin
            job_t jb;
            jb = JOBS[j];
            cur_saddr = jb.saddr;
            stall_en = jb.stall;
            cpu_wr(2'd0, jb.saddr);
            cpu_wr(2'd1, jb.cnt);
            cpu_wr(2'd2, {14'd0, jb.dir, 1'b0});
            clear_mon();
            cpu_wr(2'd2, {14'd0, jb.dir, 1'b1});
            for (int i = 0; i < 50 && !breq_o; i++) @(negedge clk);
            check(breq_o == 1, "R3 request raised", breq_o, 1);
            if (jb.busy_wr) begin
                cpu_wr(2'd0, 16'hFFFF);
                cpu_wr(2'd1, 16'h0077);
                cpu_wr(2'd2, 16'h0000);
            end
            repeat (jb.gdly) @(negedge clk);
            check(breq_o == 1 && !bus_own_o, "R3 request held without grant", bus_own_o, 0);
            bgnt_i = 1;
            wait_irq();
            check(early == 0, "R3 strobe before grant", early, 0);
            check(conflict == 0, "R12 strobe conflict", conflict, 0);
            check(strobe_cyc == 2 * int'(jb.cnt), "R6 strobe cycles", strobe_cyc, 2 * int'(jb.cnt));
            check(ack_idx == int'(jb.cnt), "R6 ack count", ack_idx, int'(jb.cnt));
            for (int k = 0; k < int'(jb.cnt); k++) begin
                if (jb.dir)
                    check(sink[k] == mem_init(int'(jb.saddr) + k), "R4 word to peripheral",
                          sink[k], mem_init(int'(jb.saddr) + k));
                else
                    check(mem[jb.saddr[7:0] + 8'(k)] == 16'hA000 + jb.saddr + 16'(k),
                          "R5 word to memory", mem[jb.saddr[7:0] + 8'(k)],
                          16'hA000 + jb.saddr + 16'(k));
            end
            check(irq_cnt == 1 && irq_bad == 0 && irq_after_strobe,
                  "R8 interrupt and bus release", irq_cnt, 1);
            cpu_rd(2'd0, v);
            check(v == jb.saddr + jb.cnt, "R7/R11 final address", v, jb.saddr + jb.cnt);
            cpu_rd(2'd1, v); check(v == 0, "R7 final count", v, 0);
            cpu_rd(2'd3, v); check(v == 16'h0002, "R8 status done", v, 2);
            cpu_rd(2'd2, v); check(v[0] == 0, "R8 start cleared", v, {15'd0, jb.dir});
        end
        stall_en = 0;

        // R9: zero count
        cpu_wr(2'd1, 16'h0000);
        clear_mon();
        cpu_wr(2'd2, 16'h0003);
        repeat (6) @(negedge clk);
        check(breq_seen == 0 && strobe_cyc == 0, "R9 no bus activity", breq_seen + strobe_cyc, 0);
        check(irq_cnt == 1, "R9 interrupt", irq_cnt, 1);
        cpu_rd(2'd3, v); check(v == 16'h0002, "R9 done", v, 2);

        // R10: control write clears done
        cpu_wr(2'd2, 16'h0000);
        cpu_rd(2'd3, v); check(v == 0, "R10 done cleared", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule